// File: doc/BRIEF.md
# Register Window Pointer Controller

This block holds the current window pointer of a circular, windowed register file that has a configurable number of windows, `NWIN`. Each window move is requested by a one-cycle strobe: save (move down), restore (move up), return-from-trap (move up and re-enable traps), or status write (load every status field from a data bus).

Before a move is committed, the target window is looked up in an invalid-window mask. A set bit blocks the move and raises a trap. The controller owns the status flags: trap enable, supervisor, previous supervisor, FPU enable, interrupt level and condition codes. It presents them both as separate outputs and as one packed status word. Traps come out as a one-cycle valid pulse with a two-bit code. The register storage, trap vectoring and interrupt arbitration are left to neighbouring blocks.

All state is held in registers with a synchronous, active-high reset. A strobe applied before a rising edge is reflected on every output right after that edge.

Top module: `win_ptr_ctrl`

## Requirements
- R1: A granted save moves the pointer from p to p-1, and from 0 to NWIN-1.
- R2: A granted restore moves the pointer from p to p+1, and from NWIN-1 to 0.
- R3: When the mask bit at the target window is set, the pointer stays where it is. A save reports overflow (code 1) and a restore reports underflow (code 2).
- R4: A return-from-trap issued while trap enable is 1 reports illegal (code 3) and changes no state.
- R5: Otherwise, a return-from-trap moves the pointer up by one under the R3 mask check, sets trap enable and copies previous-supervisor into supervisor. If the move underflows (code 2), no state changes.
- R6: A status write whose pointer field (bits 4:0) is NWIN or more reports illegal (code 3) and changes no state.
- R7: A legal status write loads these fields, and the status word reads them back at the same positions:
  - pointer in bits 4:0
  - trap enable in bit 5
  - previous supervisor in bit 6
  - supervisor in bit 7
  - interrupt level in bits 11:8
  - FPU enable in bit 12
  - condition codes N, Z, V, C in bits 23, 22, 21, 20

  All other bits are ignored on write and read as 0.
- R8: The trap valid output is high for exactly the one cycle after a trapping request, with the code in that cycle. The code is 0 whenever valid is low.
- R9: Only one request is served per cycle, in the priority order return-from-trap, save, restore, status write. Lower-priority strobes in that cycle are dropped.
- R10: Synchronous reset sets the pointer to 0, clears trap enable, sets supervisor and clears all other fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| save_req | input | 1 | Save strobe |
| restore_req | input | 1 | Restore strobe |
| rett_req | input | 1 | Return-from-trap strobe |
| wrstat_req | input | 1 | Status write strobe |
| wr_data | input | 32 | Status write data |
| inv_mask | input | 2**CW | Invalid-window mask, one bit per window |
| win_ptr | output | CW | Current window pointer |
| trap_en | output | 1 | Trap enable flag |
| sup_mode | output | 1 | Supervisor flag |
| prev_sup | output | 1 | Previous supervisor flag |
| fpu_en | output | 1 | FPU enable flag |
| irq_level | output | 4 | Interrupt level |
| cond_codes | output | 4 | N, Z, V, C |
| stat_word | output | 32 | Packed status word |
| trap_valid | output | 1 | Trap pulse |
| trap_code | output | 2 | 0 none, 1 overflow, 2 underflow, 3 illegal |

## Verification
Two strobes can arrive in the same cycle, for example a save together with a restore, or a save together with a status write. The controller then has to pick one and drop the other.

The stimulus table drives such pairs in one cycle, including return-from-trap with save and save with status write. The check is on the pointer and the flags after the edge: they must show only the effect of the higher-priority request. A status write that lost to a save must leave no trace in the pointer or the flags.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {
    TRAP_NONE = 2'd0,
    TRAP_OVF  = 2'd1,
    TRAP_UNF  = 2'd2,
    TRAP_ILL  = 2'd3
  } trap_e;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_RETT,
    OP_SAVE,
    OP_RESTORE,
    OP_WRSTAT
  } op_e;

  localparam int ET_BIT  = 5;
  localparam int PS_BIT  = 6;
  localparam int S_BIT   = 7;
  localparam int PIL_LO  = 8;
  localparam int FPU_BIT = 12;
  localparam int CC_LO   = 20;
endpackage

// File: rtl/wpc_step.sv
module wpc_step #(
  parameter int NWIN = 8,
  parameter int CW   = 5
) (
  input  logic [CW-1:0] cur,
  output logic [CW-1:0] dn,
  output logic [CW-1:0] up
);
  localparam logic [CW-1:0] TOP_W = CW'(NWIN - 1);
  localparam bit POW2 = ((NWIN & (NWIN - 1)) == 0);

  generate
    if (POW2) begin : g_pow2
      always_comb begin
        dn = (cur - 1'b1) & TOP_W;
        up = (cur + 1'b1) & TOP_W;
      end
    end else begin : g_cmp
      always_comb begin
        dn = (cur == '0)    ? TOP_W : cur - 1'b1;
        up = (cur == TOP_W) ? '0    : cur + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/wpc_decide.sv
module wpc_decide
  import wpc_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = 5,
  parameter int MW   = 32
) (
  input  logic          save_req,
  input  logic          restore_req,
  input  logic          rett_req,
  input  logic          wrstat_req,
  input  logic [31:0]   wr_data,
  input  logic [MW-1:0] inv_mask,
  input  logic [CW-1:0] cur,
  input  logic [CW-1:0] dn,
  input  logic [CW-1:0] up,
  input  logic          et_cur,
  output logic          move,
  output logic [CW-1:0] ptr_nx,
  output logic          rett_ok,
  output logic          load_all,
  output trap_e         code
);
  localparam logic [CW-1:0] TOP_W = CW'(NWIN - 1);

  op_e op;

  always_comb begin
    if (rett_req)         op = OP_RETT;
    else if (save_req)    op = OP_SAVE;
    else if (restore_req) op = OP_RESTORE;
    else if (wrstat_req)  op = OP_WRSTAT;
    else                  op = OP_IDLE;
  end

  always_comb begin
    move     = 1'b0;
    ptr_nx   = cur;
    rett_ok  = 1'b0;
    load_all = 1'b0;
    code     = TRAP_NONE;
    case (op)
      OP_SAVE: begin
        if (inv_mask[dn]) code = TRAP_OVF;
        else begin
          move   = 1'b1;
          ptr_nx = dn;
        end
      end
      OP_RESTORE: begin
        if (inv_mask[up]) code = TRAP_UNF;
        else begin
          move   = 1'b1;
          ptr_nx = up;
        end
      end
      OP_RETT: begin
        if (et_cur)            code = TRAP_ILL;
        else if (inv_mask[up]) code = TRAP_UNF;
        else begin
          move    = 1'b1;
          ptr_nx  = up;
          rett_ok = 1'b1;
        end
      end
      OP_WRSTAT: begin
        if (wr_data[CW-1:0] > TOP_W) code = TRAP_ILL;
        else begin
          move     = 1'b1;
          ptr_nx   = wr_data[CW-1:0];
          load_all = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/wpc_stat_pack.sv
module wpc_stat_pack
  import wpc_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic [CW-1:0] ptr,
  input  logic          et,
  input  logic          ps,
  input  logic          s,
  input  logic [3:0]    pil,
  input  logic          fpu,
  input  logic [3:0]    cc,
  output logic [31:0]   word
);
  always_comb begin
    word                     = '0;
    word[CW-1:0]             = ptr;
    word[ET_BIT]             = et;
    word[PS_BIT]             = ps;
    word[S_BIT]              = s;
    word[PIL_LO +: 4]        = pil;
    word[FPU_BIT]            = fpu;
    word[CC_LO +: 4]         = cc;
  end
endmodule

// File: rtl/win_ptr_ctrl.sv
module win_ptr_ctrl
  import wpc_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = 5,
  localparam int MW  = 1 << CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          save_req,
  input  logic          restore_req,
  input  logic          rett_req,
  input  logic          wrstat_req,
  input  logic [31:0]   wr_data,
  input  logic [MW-1:0] inv_mask,
  output logic [CW-1:0] win_ptr,
  output logic          trap_en,
  output logic          sup_mode,
  output logic          prev_sup,
  output logic          fpu_en,
  output logic [3:0]    irq_level,
  output logic [3:0]    cond_codes,
  output logic [31:0]   stat_word,
  output logic          trap_valid,
  output logic [1:0]    trap_code
);
  logic [CW-1:0] dn, up, ptr_nx;
  logic          move, rett_ok, load_all;
  trap_e         code;

  wpc_step #(.NWIN(NWIN), .CW(CW)) u_step (
    .cur(win_ptr), .dn(dn), .up(up)
  );

  wpc_decide #(.NWIN(NWIN), .CW(CW), .MW(MW)) u_decide (
    .save_req(save_req), .restore_req(restore_req), .rett_req(rett_req),
    .wrstat_req(wrstat_req), .wr_data(wr_data), .inv_mask(inv_mask),
    .cur(win_ptr), .dn(dn), .up(up), .et_cur(trap_en),
    .move(move), .ptr_nx(ptr_nx), .rett_ok(rett_ok),
    .load_all(load_all), .code(code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      win_ptr    <= '0;
      trap_en    <= 1'b0;
      sup_mode   <= 1'b1;
      prev_sup   <= 1'b0;
      fpu_en     <= 1'b0;
      irq_level  <= '0;
      cond_codes <= '0;
      trap_valid <= 1'b0;
      trap_code  <= TRAP_NONE;
    end else begin
      trap_valid <= (code != TRAP_NONE);
      trap_code  <= code;
      if (move) win_ptr <= ptr_nx;
      if (rett_ok) begin
        trap_en  <= 1'b1;
        sup_mode <= prev_sup;
      end
      if (load_all) begin
        trap_en    <= wr_data[ET_BIT];
        prev_sup   <= wr_data[PS_BIT];
        sup_mode   <= wr_data[S_BIT];
        irq_level  <= wr_data[PIL_LO +: 4];
        fpu_en     <= wr_data[FPU_BIT];
        cond_codes <= wr_data[CC_LO +: 4];
      end
    end
  end

  wpc_stat_pack #(.CW(CW)) u_pack (
    .ptr(win_ptr), .et(trap_en), .ps(prev_sup), .s(sup_mode),
    .pil(irq_level), .fpu(fpu_en), .cc(cond_codes), .word(stat_word)
  );
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
  parameter int NWIN = 8,
  parameter int CW   = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          rett_req,
  input logic [CW-1:0] win_ptr,
  input logic          trap_en,
  input logic          sup_mode,
  input logic          trap_valid,
  input logic [1:0]    trap_code
);
  localparam logic [CW-1:0] TOP_W = CW'(NWIN - 1);

  // R1
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    win_ptr <= TOP_W);

  // R8
  code_valid_chk: assert property (@(posedge clk) disable iff (rst)
    trap_valid == (trap_code != 2'd0));

  // R3
  trap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> $stable(win_ptr));

  // R5
  rett_ok_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rett_req) && !trap_valid) |-> trap_en);

  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (win_ptr == '0 && !trap_en && sup_mode && !trap_valid));
endmodule

bind win_ptr_ctrl wpc_checker #(.NWIN(NWIN), .CW(CW)) u_wpc_chk (
  .clk(clk), .rst(rst), .rett_req(rett_req), .win_ptr(win_ptr),
  .trap_en(trap_en), .sup_mode(sup_mode), .trap_valid(trap_valid),
  .trap_code(trap_code)
);

// File: tb/test_win_ptr_ctrl.sv
`timescale 1ns/1ps
module test_win_ptr_ctrl;
  localparam int NWIN = 8;
  localparam int CW   = 5;
  localparam int MW   = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic save_req = 0, restore_req = 0, rett_req = 0, wrstat_req = 0;
  logic [31:0] wr_data = '0;
  logic [MW-1:0] inv_mask = '0;
  logic [CW-1:0] win_ptr;
  logic trap_en, sup_mode, prev_sup, fpu_en, trap_valid;
  logic [3:0] irq_level, cond_codes;
  logic [31:0] stat_word;
  logic [1:0] trap_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  win_ptr_ctrl #(.NWIN(NWIN), .CW(CW)) i_win_ptr_ctrl (
    .clk(clk), .rst(rst), .save_req(save_req), .restore_req(restore_req),
    .rett_req(rett_req), .wrstat_req(wrstat_req), .wr_data(wr_data),
    .inv_mask(inv_mask), .win_ptr(win_ptr), .trap_en(trap_en),
    .sup_mode(sup_mode), .prev_sup(prev_sup), .fpu_en(fpu_en),
    .irq_level(irq_level), .cond_codes(cond_codes), .stat_word(stat_word),
    .trap_valid(trap_valid), .trap_code(trap_code)
  );

  // op bits: 0 save, 1 restore, 2 rett, 3 status write
  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] wd;
    logic [31:0] mask;
    logic [4:0]  ptr;
    logic [1:0]  code;
    logic        et;
    logic        s;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{4'h1, 32'h0,        32'h0,  5'd7, 2'd0, 1'b0, 1'b1}, // R1 wrap
    '{4'h1, 32'h0,        32'h0,  5'd6, 2'd0, 1'b0, 1'b1}, // R1
    '{4'h2, 32'h0,        32'h0,  5'd7, 2'd0, 1'b0, 1'b1}, // R2
    '{4'h2, 32'h0,        32'h0,  5'd0, 2'd0, 1'b0, 1'b1}, // R2 wrap
    '{4'h1, 32'h0,        32'h80, 5'd0, 2'd1, 1'b0, 1'b1}, // R3 overflow
    '{4'h2, 32'h0,        32'h2,  5'd0, 2'd2, 1'b0, 1'b1}, // R3 underflow
    '{4'h4, 32'h0,        32'h0,  5'd1, 2'd0, 1'b1, 1'b0}, // R5
    '{4'h4, 32'h0,        32'h0,  5'd1, 2'd3, 1'b1, 1'b0}, // R4
    '{4'h8, 32'h8,        32'h0,  5'd1, 2'd3, 1'b1, 1'b0}, // R6 at NWIN
    '{4'h8, 32'h00901AC5, 32'h0,  5'd5, 2'd0, 1'b0, 1'b1}, // R7
    '{4'h4, 32'h0,        32'h40, 5'd5, 2'd2, 1'b0, 1'b1}, // R5 underflow
    '{4'h4, 32'h0,        32'h0,  5'd6, 2'd0, 1'b1, 1'b1}, // R5 s<=ps
    '{4'h3, 32'h0,        32'h0,  5'd5, 2'd0, 1'b1, 1'b1}, // R9 save>restore
    '{4'h8, 32'h7,        32'h0,  5'd7, 2'd0, 1'b0, 1'b0}, // R7 top window
    '{4'h9, 32'h0,        32'h0,  5'd6, 2'd0, 1'b0, 1'b0}, // R9 save>wrstat
    '{4'h5, 32'h0,        32'h0,  5'd7, 2'd0, 1'b1, 1'b0}, // R9 rett>save
    '{4'h2, 32'h0,        32'h1,  5'd7, 2'd2, 1'b1, 1'b0}, // R3
    '{4'h2, 32'h0,        32'h0,  5'd0, 2'd0, 1'b1, 1'b0}, // R2 wrap
    '{4'h8, 32'h1F,       32'h0,  5'd0, 2'd3, 1'b1, 1'b0}  // R6 max
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] wd, input logic [31:0] m);
    @(negedge clk);
    save_req    = op[0];
    restore_req = op[1];
    rett_req    = op[2];
    wrstat_req  = op[3];
    wr_data     = wd;
    inv_mask    = m;
    @(negedge clk);
    save_req = 0; restore_req = 0; rett_req = 0; wrstat_req = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 ptr", 32'(win_ptr), 32'd0);
    check("R10 flags", {29'd0, trap_en, sup_mode, trap_valid}, 32'b010);
    check("R10 word", stat_word, 32'h80);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i].op, TBL[i].wd, TBL[i].mask);
      check($sformatf("R1/R2/R3 vec%0d ptr", i), 32'(win_ptr), 32'(TBL[i].ptr));
      check($sformatf("R8 vec%0d code", i), {29'd0, trap_valid, trap_code},
            {29'd0, TBL[i].code != 2'd0, TBL[i].code});
      check($sformatf("R5/R9 vec%0d flags", i), {30'd0, trap_en, sup_mode},
            {30'd0, TBL[i].et, TBL[i].s});
    end

    // R8 pulse lasts one cycle
    apply(4'h8, 32'h1F, 32'h0);
    @(negedge clk);
    check("R8 pulse end", {30'd0, trap_valid, trap_code != 2'd0}, 32'd0);

    // R7 field positions, unused bits ignored
    apply(4'h8, 32'h80901AC5 | 32'h000F0000, 32'h0);
    check("R7 word", stat_word, 32'h00901AC5);
    check("R7 fields", {20'd0, fpu_en, irq_level, cond_codes, 3'd0},
          {20'd0, 1'b1, 4'hA, 4'h9, 3'd0});

    // R6 illegal write leaves every field
    apply(4'h8, 32'h0000000C, 32'h0);
    check("R6 word unchanged", stat_word, 32'h00901AC5);

    // R10 reset again from a nonzero state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 re-reset", stat_word, 32'h80);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule